// File: doc/BRIEF.md
# Sync-Locked Convolutional Deinterleaver

The block receives a demodulated byte stream made of 204-byte transport packets, each opening with an MPEG-2 sync byte. It first searches for packet alignment. It counts sync bytes that arrive exactly one packet apart. The sync byte is 0x47 in its normal form and 0xB8 in its inverted form. Once enough of these sync bytes have been seen, it enters a tracking phase. In that phase every accepted byte is steered round a 12-branch Forney convolutional deinterleaver held in one internal RAM.

The first deinterleaved byte appears only after every delay line has been filled with bytes received since lock. From then on each accepted byte yields one output byte in the following cycle, with a valid flag and a packet-start flag. While tracking, the block keeps checking the sync position. A programmable run of missing sync bytes sends it back to search and stops its output. Reed-Solomon decoding and descrambling are done downstream.

Top module: `sync_deinterleaver`

## Requirements
- R1: A byte counts as sync when it is 0x47 or 0xB8. The two values are equivalent for both acquisition and tracking.
- R2: In search, the block locks on the accepted sync byte that completes a run of `lock_cnt_i` consecutive sync bytes spaced 204 accepted bytes apart. A value of 0 acts as 1. `locked_o` is 1 from the cycle after that byte.
- R3: In search, a non-sync byte at the expected sync position resets the run to zero. Only a later sync byte can start a new run.
- R4: While tracking, the byte at packet position p (the sync byte is position 0) goes to branch p mod 12. The commutator therefore restarts at branch 0 on every sync position. Branch j returns the byte written (11-j)*17 visits earlier to that branch. The result is registered on `out_data_o` one cycle after the byte is accepted.
- R5: After each lock, `out_valid_o` stays 0 until 2244 bytes have been accepted. The lock byte itself counts as the first of these. The 2245th accepted byte produces the first valid output.
- R6: `out_sop_o` is 1 exactly on valid outputs produced by a byte at packet position 0.
- R7: While tracking, a non-sync byte at position 0 increments a miss count. A sync byte at position 0 clears it. The block stays locked while the count remains below `unlock_cnt_i`.
- R8: While tracking, the non-sync byte at position 0 that brings the miss count to `unlock_cnt_i` (0 acts as 1) unlocks the block. That byte produces no output. `locked_o` and `out_valid_o` are 0 in the next cycle, and search restarts with an empty run.
- R9: A cycle with `in_valid_i` low changes no state, whatever `in_data_i` holds, and gives `out_valid_o` = 0 in the next cycle.
- R10: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte strobe |
| in_data_i | input | 8 | Demodulated input byte |
| lock_cnt_i | input | CNT_W | Consecutive sync bytes needed to lock |
| unlock_cnt_i | input | CNT_W | Consecutive missed sync bytes that unlock |
| out_valid_o | output | 1 | Deinterleaved byte valid |
| out_data_o | output | 8 | Deinterleaved byte |
| out_sop_o | output | 1 | Output byte is a packet start |
| locked_o | output | 1 | Tracking phase active |

## Verification
The riskiest cycle is the one where lock acquisition coincides with the commutator restart. In that cycle the lock byte must land in branch 0 at a freshly cleared pointer, while the fill count also starts. A second such cycle is the one where an unlocking miss falls on a byte that would otherwise have been released as valid. The bench drives a stream built by an independent interleaver formula with idle gaps inserted. It corrupts selected sync bytes so that locks, single misses, unlocks and relocks all occur while output is flowing. Each cycle's outputs are judged against a queue-based behavioural model. The locked data is also compared against the original, un-interleaved packet content.

// File: rtl/dil_pkg.sv
`timescale 1ns/1ps
package dil_pkg;

  localparam logic [7:0] SYNC_BYTE = 8'h47;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_TRACK  = 1'b1
  } trk_state_e;

  // delay (in branch visits) of branch j
  function automatic int branch_len(input int j, input int nb, input int unit);
    return unit * (nb - 1 - j);
  endfunction

  // start address of branch j in the shared line memory
  function automatic int branch_base(input int j, input int nb, input int unit);
    return unit * (j * (nb - 1) - (j * (j - 1)) / 2);
  endfunction

  function automatic logic is_sync_byte(input logic [7:0] b);
    return (b == SYNC_BYTE) || (b == ~SYNC_BYTE);
  endfunction

endpackage

// File: rtl/dil_sync_track.sv
`timescale 1ns/1ps
module dil_sync_track
  import dil_pkg::*;
#(
  parameter  int BRANCHES = 12,
  parameter  int UNIT     = 17,
  parameter  int CNT_W    = 4,
  localparam int PKT_LEN  = BRANCHES * UNIT,
  localparam int POS_W    = $clog2(PKT_LEN),
  localparam int BR_W     = $clog2(BRANCHES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  input  logic [CNT_W-1:0] lock_cnt_i,
  input  logic [CNT_W-1:0] unlock_cnt_i,
  output logic             wr_en_o,
  output logic             restart_o,
  output logic             wr_sop_o,
  output logic [BR_W-1:0]  wr_branch_o,
  output logic             locked_o
);

  trk_state_e       state_q, state_d;
  logic [CNT_W-1:0] found_q, found_d;
  logic [CNT_W-1:0] miss_q, miss_d;
  logic [POS_W-1:0] pos_q, pos_d, pos_nxt;
  logic [BR_W-1:0]  br_q, br_d, br_nxt;

  logic             sync_hit;
  logic             at_sync;
  logic [CNT_W:0]   lock_thr, unlock_thr, found_inc, miss_inc;

  assign sync_hit   = is_sync_byte(in_data_i);
  assign at_sync    = (pos_q == '0);
  assign lock_thr   = (lock_cnt_i == '0) ? (CNT_W+1)'(1) : {1'b0, lock_cnt_i};
  assign unlock_thr = (unlock_cnt_i == '0) ? (CNT_W+1)'(1) : {1'b0, unlock_cnt_i};
  assign found_inc  = {1'b0, found_q} + 1'b1;
  assign miss_inc   = {1'b0, miss_q} + 1'b1;
  assign pos_nxt    = (pos_q == POS_W'(PKT_LEN - 1)) ? '0 : pos_q + 1'b1;
  assign br_nxt     = ((pos_nxt == '0) || (br_q == BR_W'(BRANCHES - 1))) ? '0 : br_q + 1'b1;

  always_comb begin
    state_d     = state_q;
    found_d     = found_q;
    miss_d      = miss_q;
    pos_d       = pos_q;
    br_d        = br_q;
    wr_en_o     = 1'b0;
    restart_o   = 1'b0;
    wr_sop_o    = at_sync;
    wr_branch_o = br_q;
    if (in_valid_i) begin
      unique case (state_q)
        ST_SEARCH: begin
          pos_d = pos_nxt;
          if ((found_q == '0) || at_sync) begin
            if (sync_hit) begin
              pos_d = POS_W'(1);
              br_d  = BR_W'(1);
              if (found_inc >= lock_thr) begin
                // lock byte becomes position 0 of the first tracked packet
                state_d     = ST_TRACK;
                found_d     = '0;
                miss_d      = '0;
                wr_en_o     = 1'b1;
                restart_o   = 1'b1;
                wr_sop_o    = 1'b1;
                wr_branch_o = '0;
              end else begin
                found_d = found_inc[CNT_W-1:0];
              end
            end else begin
              found_d = '0;
            end
          end
        end
        ST_TRACK: begin
          if (at_sync && !sync_hit && (miss_inc >= unlock_thr)) begin
            state_d = ST_SEARCH;
            found_d = '0;
            miss_d  = '0;
          end else begin
            wr_en_o = 1'b1;
            pos_d   = pos_nxt;
            br_d    = br_nxt;
            if (at_sync) miss_d = sync_hit ? '0 : miss_inc[CNT_W-1:0];
          end
        end
        default: state_d = ST_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SEARCH;
      found_q <= '0;
      miss_q  <= '0;
      pos_q   <= '0;
      br_q    <= '0;
    end else begin
      state_q <= state_d;
      found_q <= found_d;
      miss_q  <= miss_d;
      pos_q   <= pos_d;
      br_q    <= br_d;
    end
  end

  assign locked_o = (state_q == ST_TRACK);

endmodule

// File: rtl/dil_branch_ram.sv
`timescale 1ns/1ps
module dil_branch_ram
  import dil_pkg::*;
#(
  parameter  int BRANCHES = 12,
  parameter  int UNIT     = 17,
  localparam int DEPTH    = UNIT * BRANCHES * (BRANCHES - 1) / 2,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int PTR_W    = $clog2(UNIT * (BRANCHES - 1)),
  localparam int BR_W     = $clog2(BRANCHES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            restart_i,
  input  logic [BR_W-1:0] branch_i,
  input  logic [7:0]      data_i,
  output logic [7:0]      data_o
);

  logic [7:0]        mem_q [DEPTH];
  logic [ADDR_W-1:0] br_addr [BRANCHES];
  logic [ADDR_W-1:0] addr;
  logic              pass;
  logic [7:0]        data_q;

  for (genvar g = 0; g < BRANCHES; g++) begin : g_branch
    if (g < BRANCHES - 1) begin : g_line
      localparam int LEN  = branch_len(g, BRANCHES, UNIT);
      localparam int BASE = branch_base(g, BRANCHES, UNIT);
      logic [PTR_W-1:0] ptr_q, cur_ptr;
      logic             hit;

      assign hit         = wr_en_i && (branch_i == BR_W'(g));
      assign cur_ptr     = restart_i ? '0 : ptr_q;
      assign br_addr[g]  = ADDR_W'(BASE) + ADDR_W'(cur_ptr);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        ptr_q <= '0;
        else if (hit)       ptr_q <= (cur_ptr == PTR_W'(LEN - 1)) ? '0 : cur_ptr + 1'b1;
        else if (restart_i) ptr_q <= '0;
      end
    end else begin : g_pass
      // last branch has zero delay
      assign br_addr[g] = '0;
    end
  end

  always_comb begin
    addr = '0;
    for (int b = 0; b < BRANCHES; b++) begin
      if (branch_i == BR_W'(b)) addr = br_addr[b];
    end
  end

  assign pass = (branch_i == BR_W'(BRANCHES - 1));

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !pass) mem_q[addr] <= data_i;
  end

  // read-before-write: returns the byte stored LEN visits ago
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (wr_en_i) data_q <= pass ? data_i : mem_q[addr];
  end

  assign data_o = data_q;

endmodule

// File: rtl/sync_deinterleaver.sv
`timescale 1ns/1ps
module sync_deinterleaver
  import dil_pkg::*;
#(
  parameter  int BRANCHES = 12,
  parameter  int UNIT     = 17,
  parameter  int CNT_W    = 4,
  localparam int FILL     = BRANCHES * UNIT * (BRANCHES - 1),
  localparam int FILL_W   = $clog2(FILL + 1),
  localparam int BR_W     = $clog2(BRANCHES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  input  logic [CNT_W-1:0] lock_cnt_i,
  input  logic [CNT_W-1:0] unlock_cnt_i,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_sop_o,
  output logic             locked_o
);

  logic              wr_en, restart, wr_sop;
  logic [BR_W-1:0]   wr_branch;
  logic [FILL_W-1:0] fill_q, fill_cur;
  logic              full;
  logic              valid_q, sop_q;

  dil_sync_track #(
    .BRANCHES (BRANCHES),
    .UNIT     (UNIT),
    .CNT_W    (CNT_W)
  ) u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .in_data_i    (in_data_i),
    .lock_cnt_i   (lock_cnt_i),
    .unlock_cnt_i (unlock_cnt_i),
    .wr_en_o      (wr_en),
    .restart_o    (restart),
    .wr_sop_o     (wr_sop),
    .wr_branch_o  (wr_branch),
    .locked_o     (locked_o)
  );

  dil_branch_ram #(
    .BRANCHES (BRANCHES),
    .UNIT     (UNIT)
  ) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .restart_i (restart),
    .branch_i  (wr_branch),
    .data_i    (in_data_i),
    .data_o    (out_data_o)
  );

  assign fill_cur = restart ? '0 : fill_q;
  assign full     = (fill_cur == FILL_W'(FILL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q  <= '0;
      valid_q <= 1'b0;
      sop_q   <= 1'b0;
    end else begin
      if (wr_en && !full) fill_q <= fill_cur + 1'b1;
      valid_q <= wr_en && full;
      sop_q   <= wr_en && full && wr_sop;
    end
  end

  assign out_valid_o = valid_q;
  assign out_sop_o   = sop_q;

endmodule

// File: rtl/sync_deinterleaver_chk.sv
`timescale 1ns/1ps
module sync_deinterleaver_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic [7:0] in_data_i,
  input logic       out_valid_o,
  input logic       out_sop_o,
  input logic       locked_o
);

  a_r6_sop_has_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sop_o |-> out_valid_o);

  a_r4_out_follows_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i));

  a_r9_idle_no_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  a_r1_lock_on_sync_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(in_valid_i) &&
                        ($past(in_data_i) == 8'h47 || $past(in_data_i) == 8'hB8));

  a_r5_no_release_at_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> !out_valid_o);

  a_r8_unlock_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> !out_valid_o && $past(in_valid_i) &&
                        $past(in_data_i) != 8'h47 && $past(in_data_i) != 8'hB8);

  a_r8_valid_only_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> locked_o);

endmodule

bind sync_deinterleaver sync_deinterleaver_chk u_chk (.*);

// File: tb/sync_deinterleaver_bench.sv
`timescale 1ns/1ps
module sync_deinterleaver_bench;
  localparam int NB   = 12;
  localparam int UNIT = 17;
  localparam int PKT  = NB * UNIT;
  localparam int FILL = NB * UNIT * (NB - 1);
  localparam int CW   = 4;
  localparam int LOCK_G = 2 * PKT;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic [CW-1:0] lock_cnt = CW'(3);
  logic [CW-1:0] unlock_cnt = CW'(2);
  logic          out_valid, out_sop, locked;
  logic [7:0]    out_data;

  always #2.5 clk = ~clk;

  sync_deinterleaver u_sync_deinterleaver (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid),
    .in_data_i    (in_data),
    .lock_cnt_i   (lock_cnt),
    .unlock_cnt_i (unlock_cnt),
    .out_valid_o  (out_valid),
    .out_data_o   (out_data),
    .out_sop_o    (out_sop),
    .locked_o     (locked)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural reference
  logic [7:0] mq [NB][$];
  int m_locked = 0, m_found = 0, m_pos = 0, m_miss = 0, m_fill = 0;
  logic e_valid = 0, e_sop = 0, e_locked = 0;
  logic [7:0] e_data = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] orig(input int g);
    int pkt, i;
    if (g < 0) return 8'h00;
    pkt = g / PKT;
    i   = g % PKT;
    if (i == 0) return (pkt % 8 == 0) ? 8'hB8 : 8'h47;
    return 8'((pkt * 5 + i) & 63);
  endfunction

  function automatic bit killed(input int pkt);
    return pkt == 22 || pkt == 25 || pkt == 26 || pkt == 28 || pkt == 34;
  endfunction

  // channel stream: independent Forney interleaver, branch j delays j*PKT bytes
  function automatic logic [7:0] chan(input int g);
    if (g % PKT == 0 && killed(g / PKT)) return 8'h00;
    return orig(g - (g % NB) * PKT);
  endfunction

  task automatic model_write(input logic [7:0] d, input int cur);
    int j, len;
    logic [7:0] o;
    j   = cur % NB;
    len = (NB - 1 - j) * UNIT;
    mq[j].push_back(d);
    o = 8'h00;
    if (mq[j].size() > len) o = mq[j].pop_front();
    e_valid = (m_fill >= FILL);
    e_sop   = e_valid && (cur == 0);
    e_data  = o;
    if (m_fill < FILL) m_fill++;
  endtask

  task automatic model_step(input bit v, input logic [7:0] d);
    bit s;
    int thr, uthr, cur;
    e_valid = 0;
    e_sop   = 0;
    if (v) begin
      s    = (d == 8'h47) || (d == 8'hB8);
      thr  = (lock_cnt == 0) ? 1 : int'(lock_cnt);
      uthr = (unlock_cnt == 0) ? 1 : int'(unlock_cnt);
      if (m_locked == 0) begin
        if (m_found == 0 || m_pos == 0) begin
          if (s) begin
            m_found++;
            m_pos = 1;
            if (m_found >= thr) begin
              m_locked = 1; m_found = 0; m_miss = 0; m_fill = 0;
              for (int j = 0; j < NB; j++) mq[j].delete();
              model_write(d, 0);
            end
          end else begin
            m_found = 0;
            m_pos = (m_pos + 1) % PKT;
          end
        end else begin
          m_pos = (m_pos + 1) % PKT;
        end
      end else begin
        cur = m_pos;
        if (cur == 0 && !s && m_miss + 1 >= uthr) begin
          m_locked = 0; m_found = 0; m_miss = 0;
        end else begin
          if (cur == 0) m_miss = s ? 0 : m_miss + 1;
          m_pos = (cur + 1) % PKT;
          model_write(d, cur);
        end
      end
    end
    e_locked = (m_locked != 0);
  endtask

  task automatic compare_all();
    chk(locked == e_locked, "R2 R7 R8 locked", int'(locked), int'(e_locked));
    chk(out_valid == e_valid, "R5 R9 out_valid", int'(out_valid), int'(e_valid));
    if (e_valid) begin
      chk(out_sop == e_sop, "R6 out_sop", int'(out_sop), int'(e_sop));
      chk(out_data == e_data, "R4 out_data", int'(out_data), int'(e_data));
    end
  endtask

  int e2e_k = 0;

  task automatic targeted(input int pg, input int g_now);
    if (pg == -1 && rst_ni)
      chk(!out_valid, "R9 idle cycle output", int'(out_valid), 0);
    if (out_valid && g_now <= 22 * PKT) begin
      chk(out_data == orig(LOCK_G + e2e_k), "R4 end-to-end data", int'(out_data),
          int'(orig(LOCK_G + e2e_k)));
      e2e_k++;
    end
    case (pg)
      LOCK_G - 1: chk(!locked, "R2 before third sync", int'(locked), 0);
      LOCK_G: begin
        chk(locked, "R1 R2 lock on third sync", int'(locked), 1);
        chk(!out_valid, "R5 lock byte not released", int'(out_valid), 0);
      end
      LOCK_G + FILL - 1: chk(!out_valid, "R5 still filling", int'(out_valid), 0);
      LOCK_G + FILL: chk(out_valid && out_sop, "R5 R6 first output", int'({out_valid, out_sop}), 3);
      24 * PKT: chk(locked, "R7 single miss tolerated", int'(locked), 1);
      25 * PKT: chk(locked, "R7 miss count cleared by sync", int'(locked), 1);
      26 * PKT: chk(!locked && !out_valid, "R8 unlock after two misses",
                    int'({locked, out_valid}), 0);
      30 * PKT: chk(!locked, "R3 broken run restarts", int'(locked), 0);
      31 * PKT: chk(locked, "R3 relock after fresh run", int'(locked), 1);
      34 * PKT: chk(!locked, "R8 unlock count one", int'(locked), 0);
      35 * PKT: chk(locked, "R2 lock count zero acts as one", int'(locked), 1);
      35 * PKT + FILL: chk(out_valid && out_sop, "R5 R6 output after relock",
                           int'({out_valid, out_sop}), 3);
      default: ;
    endcase
  endtask

  initial begin
    int g, cyc, prev_g;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R10 reset out_valid", int'(out_valid), 0);
    chk(!out_sop, "R10 reset out_sop", int'(out_sop), 0);
    chk(!locked, "R10 reset locked", int'(locked), 0);
    chk(out_data == 8'h00, "R10 reset out_data", int'(out_data), 0);
    rst_ni = 1'b1;
    g = 0; cyc = 0; prev_g = -1;
    while (g < 50 * PKT) begin
      @(negedge clk);
      compare_all();
      targeted(prev_g, g);
      if (g >= 33 * PKT) unlock_cnt = CW'(1);
      if (g >= 34 * PKT + 1) lock_cnt = CW'(0);
      cyc++;
      if (cyc % 7 == 3) begin
        in_valid = 1'b0;
        in_data  = 8'hB8;
        model_step(0, in_data);
        prev_g = -1;
      end else begin
        in_valid = 1'b1;
        in_data  = chan(g);
        model_step(1, in_data);
        prev_g = g;
        g++;
      end
    end
    @(negedge clk);
    compare_all();
    targeted(prev_g, g);
    in_valid = 1'b0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R10 watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule